// File: doc/BRIEF.md
# Tabular Prime Implicant Engine

This block finds every prime implicant of a Boolean function of four variables. The function arrives as two 16-bit masks: the ON-set (minterms where the function is 1) and the don't-care set. A single start pulse launches the run. The engine seeds its cube store with every ON and don't-care minterm. It then merges cubes one level at a time: 0-cubes, then 1-cubes, and so on. Two cubes merge only when they share the same free positions and the second holds exactly one more 1 bit, placed in a single position. Any cube that takes part in a merge is marked as used. The unmarked cubes that survive are the primes.

When the run ends, the engine raises `done` and reports the number of primes. Each prime is then read through an index port as a ternary cube, given as a value nibble and a free-bit nibble. Bit i of both nibbles refers to bit i of the minterm index. A prime that covers only don't-care minterms is left out of the list. Choosing a cover and building a netlist are the job of later stages.

Top module: `qm_prime_engine`

## Requirements
- R1: While reset is held and directly after it, `busy`, `done` and `prime_count` are 0.
- R2: When `start` is sampled high while `busy` is low, the engine latches `on_set` and `dc_set`. It drives `busy` high and `done` low from the next cycle on. A `start` sampled while `busy` is high has no effect on the results or on the timing.
- R3: The prime list matches the tabular procedure. The seeds are the minterms of on_set|dc_set. Cubes merge only with a cube of the same free mask whose value has exactly one extra 1 bit, and that bit becomes free in the new cube. Merging repeats level by level. Example: ON {0,4,8,10,11,12,13,15} with no don't-cares gives 6 primes. Example: ON {0,3,10,15} with don't-cares {1,2,7,8,11,14} gives 5 primes.
- R4: Each cube is read as `rd_value` (bit i = minterm bit i where fixed) and `rd_free` (bit i = 1 where that variable is free). Value bits under a free bit always read 0.
- R5: Only cubes never marked as merged are reported, and a cube produced by several merges appears once.
- R6: A prime whose minterms all lie outside the ON-set is dropped. An empty ON-set gives `prime_count` = 0.
- R7: Entries 0 to `prime_count`-1 are sorted in ascending order of the 8-bit key {rd_free, rd_value}, with rd_free in the upper nibble.
- R8: Let S be the number of the largest free-bit count over all generated cubes, plus 1, capped at 4. `done` rises exactly 256*(S+1) cycles after the edge that accepted `start`. `busy` stays high from that edge until then and is never high together with `done`.
- R9: After `done` rises, `done`, `prime_count` and the list stay unchanged until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run with the current masks |
| on_set | input | 16 | ON-set minterm mask, bit m = minterm m |
| dc_set | input | 16 | Don't-care minterm mask |
| rd_idx | input | $clog2(MAX_PRIMES) | Index of the prime to read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid |
| prime_count | output | $clog2(MAX_PRIMES+1) | Number of primes in the list |
| rd_value | output | 4 | Fixed bit values of the indexed prime |
| rd_free | output | 4 | Free-bit mask of the indexed prime |

## Verification
Some faults in the cube store show up only at the end of the run, as an extra or a missing entry in the prime list. A lost merge, a missed used-mark or a duplicate cube are faults of this kind. The bench compares the whole sorted list against a queue-based model of the tabular method. A fault in level sequencing shows up much earlier. A level counter that stops early or runs on moves `done` by a multiple of 256 cycles. The per-clock comparison of `busy` and `done` against the model's latency reports this on the first cycle where they differ.

// File: rtl/qm_prime_engine.sv
module qm_prime_engine #(
  parameter int MAX_PRIMES = 32,
  localparam int IW = $clog2(MAX_PRIMES),
  localparam int CW = $clog2(MAX_PRIMES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   on_set,
  input  logic [15:0]   dc_set,
  input  logic [IW-1:0] rd_idx,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] prime_count,
  output logic [3:0]    rd_value,
  output logic [3:0]    rd_free
);
  localparam int NV = 4;
  localparam int NM = 1 << NV;
  localparam int NC = 1 << (2 * NV);

  typedef enum logic [1:0] {S_IDLE, S_MERGE, S_COLLECT, S_DONE} st_t;

  st_t             st;
  logic [NC-1:0]   pres, used;
  logic [NM-1:0]   on_q;
  logic [7:0]      code;
  logic [2:0]      lvl;
  logic            grew;
  logic [CW-1:0]   cnt;
  logic [7:0]      plist [MAX_PRIMES];

  function automatic logic [2:0] popc4(input logic [3:0] x);
    popc4 = {2'b0, x[0]} + {2'b0, x[1]} + {2'b0, x[2]} + {2'b0, x[3]};
  endfunction

  wire [3:0] cv   = code[3:0];
  wire [3:0] cm   = code[7:4];
  wire       last = (code == 8'hFF);
  wire       on_lvl = pres[code] && (popc4(cm) == lvl);

  logic [NV-1:0] hit;
  logic          useful;

  always_comb begin
    for (int b = 0; b < NV; b++)
      hit[b] = on_lvl && !cm[b] && !cv[b] && pres[code | (8'd1 << b)];
  end

  always_comb begin
    useful = 1'b0;
    for (int m = 0; m < NM; m++)
      if (on_q[m] && (((4'(m) ^ cv) & ~cm) == 4'd0)) useful = 1'b1;
  end

  wire grew_nx = grew | (|hit);
  wire keep    = pres[code] && !used[code] && useful && (cnt < CW'(MAX_PRIMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pres <= '0;
      used <= '0;
      on_q <= '0;
      code <= '0;
      lvl  <= '0;
      grew <= 1'b0;
      cnt  <= '0;
      for (int i = 0; i < MAX_PRIMES; i++) plist[i] <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start) begin
            on_q <= on_set;
            pres <= {{(NC-NM){1'b0}}, on_set | dc_set};
            used <= '0;
            code <= '0;
            lvl  <= '0;
            grew <= 1'b0;
            cnt  <= '0;
            st   <= S_MERGE;
          end
        end
        S_MERGE: begin
          for (int b = 0; b < NV; b++) begin
            if (hit[b]) begin
              pres[code | (8'd16 << b)] <= 1'b1;
              used[code]                <= 1'b1;
              used[code | (8'd1 << b)]  <= 1'b1;
            end
          end
          code <= code + 8'd1;
          grew <= grew_nx;
          if (last) begin
            if (!grew_nx || lvl == 3'(NV - 1)) begin
              st <= S_COLLECT;
            end else begin
              lvl  <= lvl + 3'd1;
              grew <= 1'b0;
            end
          end
        end
        S_COLLECT: begin
          if (keep) begin
            plist[cnt[IW-1:0]] <= code;
            cnt <= cnt + 1'b1;
          end
          code <= code + 8'd1;
          if (last) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st == S_MERGE) || (st == S_COLLECT);
  assign done        = (st == S_DONE);
  assign prime_count = cnt;
  assign rd_value    = plist[rd_idx][3:0];
  assign rd_free     = plist[rd_idx][7:4];
endmodule

// File: rtl/qm_prime_engine_chk.sv
module qm_prime_engine_chk #(
  parameter int MAX_PRIMES = 32,
  parameter int IW = 5,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] prime_count,
  input logic [3:0]    rd_value,
  input logic [3:0]    rd_free
);
  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  p_done_from_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(prime_count)));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prime_count <= CW'(MAX_PRIMES));

  p_canon_cube_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_value & rd_free) == 4'd0);

  p_idle_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (prime_count == '0));
endmodule

bind qm_prime_engine qm_prime_engine_chk #(.MAX_PRIMES(MAX_PRIMES), .IW(IW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .prime_count(prime_count), .rd_value(rd_value), .rd_free(rd_free)
);

// File: tb/qm_prime_engine_tb_top.sv
module qm_prime_engine_tb_top;
  localparam int MAXP = 32;
  localparam int IW = $clog2(MAXP);
  localparam int CW = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] on_set = '0, dc_set = '0;
  logic [IW-1:0] rd_idx = '0;
  logic busy, done;
  logic [CW-1:0] prime_count;
  logic [3:0] rd_value, rd_free;

  always #5 clk = ~clk;

  qm_prime_engine #(.MAX_PRIMES(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .on_set(on_set), .dc_set(dc_set),
    .rd_idx(rd_idx), .busy(busy), .done(done), .prime_count(prime_count),
    .rd_value(rd_value), .rd_free(rd_free));

  int n_chk = 0, n_fail = 0;
  int exp_keys[$];
  int exp_s = 1;
  bit mon_en = 1'b0;
  bit m_busy = 1'b0, m_done = 1'b0;
  int m_left = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int pc(input int x);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (x >> i) & 1;
    return c;
  endfunction

  task automatic compute_ref(input logic [15:0] on, input logic [15:0] dc);
    int cur[$], nxt[$], primes[$];
    bit mark[int];
    int maxl = 0;
    exp_keys = {};
    for (int m = 0; m < 16; m++) if (on[m] || dc[m]) cur.push_back(m);
    for (int l = 0; l < 5 && cur.size() > 0; l++) begin
      nxt = {};
      mark.delete();
      foreach (cur[i]) foreach (cur[j]) begin
        int va = cur[i] & 15, vb = cur[j] & 15, ma = cur[i] >> 4, mb = cur[j] >> 4;
        if (ma == mb && pc(vb) == pc(va) + 1 && pc(va ^ vb) == 1) begin
          int nk = ((ma | (va ^ vb)) << 4) | va;
          bit dup = 1'b0;
          mark[cur[i]] = 1'b1;
          mark[cur[j]] = 1'b1;
          foreach (nxt[k]) if (nxt[k] == nk) dup = 1'b1;
          if (!dup) nxt.push_back(nk);
        end
      end
      foreach (cur[i]) if (!mark.exists(cur[i])) primes.push_back(cur[i]);
      if (nxt.size() > 0) maxl = l + 1;
      cur = nxt;
    end
    foreach (primes[i]) begin
      bit cov = 1'b0;
      for (int m = 0; m < 16; m++)
        if (on[m] && (((m ^ primes[i]) & ~(primes[i] >> 4) & 15) == 0)) cov = 1'b1;
      if (cov) exp_keys.push_back(primes[i]);
    end
    exp_keys.sort();
    exp_s = (maxl + 1 > 4) ? 4 : maxl + 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_left <= 0;
    end else if (!m_busy && start) begin
      m_busy <= 1'b1; m_done <= 1'b0; m_left <= 256 * (exp_s + 1);
    end else if (m_busy) begin
      m_left <= m_left - 1;
      if (m_left == 1) begin m_busy <= 1'b0; m_done <= 1'b1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      chk(busy === m_busy, "R2/R8", "busy per clock", int'(busy), int'(m_busy));
      chk(done === m_done, "R8", "done per clock", int'(done), int'(m_done));
    end
  end

  task automatic check_list(input string tag);
    chk(int'(prime_count) == exp_keys.size(), "R3/R5/R6", {tag, " count"}, int'(prime_count), exp_keys.size());
    foreach (exp_keys[i]) begin
      if (i < MAXP) begin
        rd_idx = IW'(i);
        #1;
        chk({rd_free, rd_value} == 8'(exp_keys[i]), "R3/R7", {tag, " entry"}, int'({rd_free, rd_value}), exp_keys[i]);
        chk((rd_value & rd_free) == 4'd0, "R4", {tag, " canonical"}, int'(rd_value & rd_free), 0);
      end
    end
  endtask

  task automatic run_case(input logic [15:0] on, input logic [15:0] dc, input string tag, input bit poke);
    compute_ref(on, dc);
    @(negedge clk);
    on_set = on; dc_set = dc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      on_set = ~on; dc_set = 16'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0; on_set = on; dc_set = dc;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check_list(tag);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lf = 32'h1D2C_3B4A;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "flags in reset", int'({busy, done}), 0);
    chk(prime_count == '0, "R1", "count in reset", int'(prime_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && prime_count == '0, "R1", "after reset", int'({busy, done}), 0);
    mon_en = 1'b1;

    run_case(16'hBD11, 16'h0000, "R3 example one", 1'b0);
    chk(int'(prime_count) == 6, "R3", "example one primes", int'(prime_count), 6);
    run_case(16'h8409, 16'h4986, "R3 example two", 1'b0);
    chk(int'(prime_count) == 5, "R3", "example two primes", int'(prime_count), 5);
    run_case(16'h0000, 16'hFFFF, "R6 only dont-cares", 1'b0);
    chk(prime_count == '0, "R6", "empty on-set", int'(prime_count), 0);
    run_case(16'h0000, 16'h0000, "R6 empty", 1'b0);
    run_case(16'hFFFF, 16'h0000, "R8 tautology", 1'b0);
    rd_idx = '0; #1;
    chk({rd_free, rd_value} == 8'hF0, "R4", "full cube", int'({rd_free, rd_value}), 8'hF0);
    run_case(16'h0020, 16'h0000, "R8 single minterm", 1'b0);
    run_case(16'hBD11, 16'h0000, "R2 start ignored while busy", 1'b1);
    repeat (50) @(negedge clk);
    chk(done == 1'b1, "R9", "done held", int'(done), 1);
    check_list("R9 held list");
    run_case(16'h6996, 16'h0000, "R5 parity", 1'b0);
    for (int t = 0; t < 6; t++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run_case(lf[15:0], lf[31:16] & lf[23:8], "R3/R5 pattern", 1'b0);
    end
    mon_en = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule